// File: doc/BRIEF.md
# PWM Channel with Shadowed Period and Width

This block drives one edge-aligned pulse-width-modulated output from an up-counting timer. Software sets the period and the pulse width through a single-cycle write port. Each setting sits in a visible register and in a shadow copy, and the comparator works from the shadow copy. While the channel runs, the shadows pick up new settings only at the period boundary, so a pulse is never cut short or stretched partway through a period.

A run input starts and stops the timer. While the channel is stopped, the shadows follow the registers directly. A width write or a timer load then shows on the output at once, which makes it easy to park the output at a chosen level. At each wrap the block raises a one-clock interrupt pulse. The present timer count can always be read back.

Top module: `pwm_shadow_chan`

## Requirements
- R1: After synchronous reset the timer reads 0, the period and width registers and their shadows all hold the all-ones value, and both `pwm_out` and `wrap_irq` are low.
- R2: While `run` is 1, the timer steps by one each clock from 0 up to the period shadow value and then returns to 0, so one period lasts period+1 clocks. A timer write takes priority over counting.
- R3: `wrap_irq` is high for exactly the one clock in which the timer has just returned from the period value to 0, and only while running.
- R4: `pwm_out` is high exactly when the timer value is greater than or equal to the width shadow value, and it changes in the same cycle as the timer.
- R5: When `run` goes to 0, the timer holds its current value until it is written or `run` returns to 1.
- R6: While `run` is 0, period and width writes go straight into the shadows, and the output reflects a new width in the cycle after the write.
- R7: While `run` is 0, loading the timer with a value at or above the width shadow sets `pwm_out` in the next cycle, and loading a value below it clears `pwm_out`.
- R8: While `run` is 1, period and width writes are held in their registers. Both shadows reload only on the clock where the timer wraps, and a write made in that same clock is the value they take.
- R9: A width of 0 gives a constant high output. A width greater than the period gives a constant low output.
- R10: The write select is 0 for the timer, 1 for the period and 2 for the width. Select 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | 1 = timer counts, 0 = timer halted and shadows transparent |
| wr_en | input | 1 | Write strobe for one clock |
| wr_sel | input | 2 | Write target: 0 timer, 1 period, 2 width, 3 none |
| wr_data | input | CNT_W | Write value |
| pwm_out | output | 1 | Registered PWM output |
| wrap_irq | output | 1 | One-clock pulse on each wrap while running |
| tmr_val | output | CNT_W | Current timer value |

## Verification
The sensitive coincidence is a width write that lands in the very clock where the timer wraps: the shadow reload and the register write meet on the same edge. The bench waits until the timer reads the period value, issues the write in that cycle, and then expects the new width to govern the first clocks of the next period. Its behavioural model is compared with the outputs on every clock. A running write made away from the boundary is also checked, and it must leave the current period's pulse shape untouched.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;
  typedef enum logic [1:0] {
    SEL_TMR  = 2'd0,
    SEL_PER  = 2'd1,
    SEL_WID  = 2'd2,
    SEL_NONE = 2'd3
  } wsel_e;
endpackage

// File: rtl/pwm_shadow_pair.sv
// Visible register plus the shadow copy the comparator uses.
module pwm_shadow_pair #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_hit,
  input  logic [W-1:0] wr_data,
  input  logic         load,
  output logic [W-1:0] q_reg,
  output logic [W-1:0] q_sh,
  output logic [W-1:0] q_sh_nxt
);
  logic [W-1:0] q_reg_nxt;

  always_comb begin
    q_reg_nxt = wr_hit ? wr_data : q_reg;
    q_sh_nxt  = load ? q_reg_nxt : q_sh;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_reg <= '1;
      q_sh  <= '1;
    end else begin
      q_reg <= q_reg_nxt;
      q_sh  <= q_sh_nxt;
    end
  end
endmodule

// File: rtl/pwm_shadow_timer.sv
module pwm_shadow_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         tmr_wr,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] per_sh,
  output logic [W-1:0] tmr,
  output logic [W-1:0] tmr_nxt,
  output logic         wrap,
  output logic         irq
);
  always_comb begin
    wrap = run && !tmr_wr && (tmr == per_sh);
    if (tmr_wr)    tmr_nxt = wr_data;
    else if (wrap) tmr_nxt = '0;
    else if (run)  tmr_nxt = tmr + 1'b1;
    else           tmr_nxt = tmr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr <= '0;
      irq <= 1'b0;
    end else begin
      tmr <= tmr_nxt;
      irq <= wrap;
    end
  end
endmodule

// File: rtl/pwm_shadow_cmp.sv
module pwm_shadow_cmp #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] tmr_nxt,
  input  logic [W-1:0] wid_nxt,
  output logic         pwm
);
  always_ff @(posedge clk) begin
    if (rst) pwm <= 1'b0;
    else     pwm <= (tmr_nxt >= wid_nxt);
  end
endmodule

// File: rtl/pwm_shadow_chan.sv
module pwm_shadow_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic             pwm_out,
  output logic             wrap_irq,
  output logic [CNT_W-1:0] tmr_val
);
  import pwm_shadow_pkg::*;

  localparam int NSH    = 2;
  localparam int IX_PER = 0;
  localparam int IX_WID = 1;

  wsel_e            sel_e;
  logic             tmr_wr;
  logic             wrap;
  logic             sh_load;
  logic [CNT_W-1:0] tmr_nxt;
  logic [CNT_W-1:0] r_q   [NSH];
  logic [CNT_W-1:0] s_q   [NSH];
  logic [CNT_W-1:0] s_nxt [NSH];
  logic [NSH-1:0]   hit;
  logic [CNT_W-1:0] per_reg, wid_reg, per_sh, wid_sh;

  assign sel_e   = wsel_e'(wr_sel);
  assign tmr_wr  = wr_en && (sel_e == SEL_TMR);
  assign hit[IX_PER] = wr_en && (sel_e == SEL_PER);
  assign hit[IX_WID] = wr_en && (sel_e == SEL_WID);
  assign sh_load = !run || wrap;

  for (genvar g = 0; g < NSH; g++) begin : g_sh
    pwm_shadow_pair #(.W(CNT_W)) u_pair (
      .clk(clk), .rst(rst), .wr_hit(hit[g]), .wr_data(wr_data),
      .load(sh_load), .q_reg(r_q[g]), .q_sh(s_q[g]), .q_sh_nxt(s_nxt[g])
    );
  end

  assign per_reg = r_q[IX_PER];
  assign wid_reg = r_q[IX_WID];
  assign per_sh  = s_q[IX_PER];
  assign wid_sh  = s_q[IX_WID];

  pwm_shadow_timer #(.W(CNT_W)) u_tmr (
    .clk(clk), .rst(rst), .run(run), .tmr_wr(tmr_wr), .wr_data(wr_data),
    .per_sh(per_sh), .tmr(tmr_val), .tmr_nxt(tmr_nxt), .wrap(wrap),
    .irq(wrap_irq)
  );

  pwm_shadow_cmp #(.W(CNT_W)) u_cmp (
    .clk(clk), .rst(rst), .tmr_nxt(tmr_nxt), .wid_nxt(s_nxt[IX_WID]),
    .pwm(pwm_out)
  );
endmodule

// File: rtl/pwm_shadow_chan_chk.sv
module pwm_shadow_chan_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic             pwm_out,
  input logic             wrap_irq,
  input logic             wrap,
  input logic [CNT_W-1:0] tmr_val,
  input logic [CNT_W-1:0] per_reg,
  input logic [CNT_W-1:0] wid_reg,
  input logic [CNT_W-1:0] per_sh,
  input logic [CNT_W-1:0] wid_sh
);
  a_r4_output_compare: assert property (@(posedge clk) disable iff (rst)
    pwm_out == (tmr_val >= wid_sh));

  a_r5_halt_holds: assert property (@(posedge clk) disable iff (rst)
    (!run && !(wr_en && wr_sel == 2'd0)) |=> $stable(tmr_val));

  a_r3_irq_at_zero: assert property (@(posedge clk) disable iff (rst)
    wrap_irq |-> (tmr_val == '0));

  a_r3_irq_needs_run: assert property (@(posedge clk) disable iff (rst)
    wrap_irq |-> $past(run));

  a_r6_stopped_transparent: assert property (@(posedge clk) disable iff (rst)
    !run |=> (wid_sh == wid_reg && per_sh == per_reg));

  a_r8_hold_until_wrap: assert property (@(posedge clk) disable iff (rst)
    (run && !wrap) |=> ($stable(wid_sh) && $stable(per_sh)));
endmodule

bind pwm_shadow_chan pwm_shadow_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .run(run), .wr_en(wr_en), .wr_sel(wr_sel),
  .pwm_out(pwm_out), .wrap_irq(wrap_irq), .wrap(wrap), .tmr_val(tmr_val),
  .per_reg(per_reg), .wid_reg(wid_reg), .per_sh(per_sh), .wid_sh(wid_sh)
);

// File: tb/pwm_shadow_chan_tb.sv
module pwm_shadow_chan_tb;
  localparam int W    = 8;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         run = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_sel = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic         pwm_out, wrap_irq;
  logic [W-1:0] tmr_val;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_tmr, m_per, m_wid, m_ps, m_ws;
  bit m_pwm, m_irq;

  always #10 clk = ~clk;

  pwm_shadow_chan #(.CNT_W(W)) u_dut (
    .clk(clk), .rst(rst), .run(run), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .pwm_out(pwm_out), .wrap_irq(wrap_irq),
    .tmr_val(tmr_val)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int np, nw, nt;
    bit wr_t, wrp;
    cyc++;
    if (rst) begin
      m_tmr = 0; m_per = MAXV; m_wid = MAXV; m_ps = MAXV; m_ws = MAXV;
      m_pwm = 0; m_irq = 0;
    end else begin
      np = (wr_en && wr_sel == 2'd1) ? int'(wr_data) : m_per;
      nw = (wr_en && wr_sel == 2'd2) ? int'(wr_data) : m_wid;
      wr_t = wr_en && wr_sel == 2'd0;
      wrp = run && !wr_t && (m_tmr == m_ps);
      if (wr_t)     nt = int'(wr_data);
      else if (wrp) nt = 0;
      else if (run) nt = (m_tmr + 1) % (MAXV + 1);
      else          nt = m_tmr;
      if (!run || wrp) begin m_ps = np; m_ws = nw; end
      m_per = np; m_wid = nw; m_tmr = nt;
      m_pwm = (m_tmr >= m_ws);
      m_irq = wrp;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(cur_req, "model timer", int'(tmr_val), m_tmr);
      chk(cur_req, "model pwm", int'(pwm_out), int'(m_pwm));
      chk(cur_req, "model irq", int'(wrap_irq), int'(m_irq));
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic wr(input int sel, input int d);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int highs;
    int lows;
    int held;
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "reset timer", int'(tmr_val), 0);
    chk("R1", "reset pwm", int'(pwm_out), 0);
    chk("R1", "reset irq", int'(wrap_irq), 0);

    // stopped: transparent shadows and direct timer loads
    cur_req = "R6";
    wr(2, 5);
    chk("R6", "pwm after width 5 at timer 0", int'(pwm_out), 0);
    cur_req = "R7";
    wr(0, 7);
    chk("R7", "pwm after timer load 7", int'(pwm_out), 1);
    wr(0, 3);
    chk("R7", "pwm after timer load 3", int'(pwm_out), 0);
    cur_req = "R6";
    wr(2, 2);
    chk("R6", "pwm after width 2 at timer 3", int'(pwm_out), 1);
    cur_req = "R10";
    wr(3, 0);
    chk("R10", "timer after select 3", int'(tmr_val), 3);
    chk("R10", "pwm after select 3", int'(pwm_out), 1);

    // run: period 9, width 4
    cur_req = "R2";
    wr(1, 9);
    wr(2, 4);
    wr(0, 0);
    run = 1'b1;
    idle(25);

    // running write away from the boundary
    cur_req = "R8";
    while (tmr_val != 8'd2) @(negedge clk);
    wr(2, 7);
    chk("R8", "pwm stays low at timer 3", int'(pwm_out), 0);
    idle(1);
    chk("R8", "old width still active at timer 4", int'(pwm_out), 1);

    // write in the wrap cycle
    while (tmr_val != 8'd9) @(negedge clk);
    wr(2, 1);
    chk("R3", "irq on wrap", int'(wrap_irq), 1);
    chk("R2", "timer wrapped", int'(tmr_val), 0);
    chk("R8", "pwm at 0 with width 1", int'(pwm_out), 0);
    idle(1);
    chk("R8", "pwm at 1 with width 1", int'(pwm_out), 1);
    chk("R3", "irq single clock", int'(wrap_irq), 0);
    idle(12);

    // halt
    cur_req = "R5";
    run = 1'b0;
    @(negedge clk);
    held = int'(tmr_val);
    idle(5);
    chk("R5", "timer held", int'(tmr_val), held);

    // extreme widths
    cur_req = "R9";
    wr(2, 0);
    wr(0, 0);
    run = 1'b1;
    highs = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      highs += int'(pwm_out);
    end
    chk("R9", "width 0 high count", highs, 20);
    run = 1'b0;
    wr(2, 20);
    run = 1'b1;
    lows = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      lows += int'(!pwm_out);
    end
    chk("R9", "width above period low count", lows, 20);
    run = 1'b0;

    cur_req = "R4";
    wr(1, 3);
    wr(2, 2);
    run = 1'b1;
    idle(10);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule